// File: doc/BRIEF.md
# Frame-Triggered Peripheral Command Walker

This block services a list of peripheral commands once per video frame. When the vertical blank strobe arrives and software has armed the block, it walks a command table in system memory through a 32-bit single-word memory master port. For every table entry it fetches a command word and a response address. It then stores a two-word "nothing attached" reply at that address and jumps to the next entry, whose position depends on the length field of the current command.

The walk ends after the entry that carries the final-entry flag. The block then clears its start register, drops `busy` and pulses `done` for one cycle. Software programs four control registers through a simple write port and reads any of them back through a registered read port. It re-arms the walk by writing the start register again.

Top module: `vbl_dma_walker`

## Requirements
- R1: After synchronous reset `busy`, `done` and `mem_valid` are 0, and all four control registers read as 0.
- R2: Register index 0 holds the table base address, 1 the enable word, 2 the start word and 3 the system-control word, all 32 bits wide. `reg_rdata` shows the register selected by `reg_addr` one cycle later, with the value it held before that clock edge.
- R3: A `vblank` pulse starts a walk only if, in that cycle, system-control bits 31:16 equal 0x3A98, the enable word equals exactly 1 and the start word equals exactly 1. `busy` rises on the next edge.
- R4: The first access of a walk is a read at the table base. Each entry is handled as a read of the command word at the entry address, followed by a read of the response address at entry + 4.
- R5: For each entry the block writes 0x00000000 to the response address and then 0xFFFFFFFF to the response address + 4.
- R6: In the command word, bit 31 marks the final entry and bits 7:0 hold the length L. The entry after a non-final one starts at entry + 8 + (L + 1) × 4.
- R7: In the cycle the second write of the final entry is accepted, the start register is cleared and `busy` falls. `done` is high for exactly the one following cycle.
- R8: Each access holds `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` steady until `mem_ready` is seen, and only one access is outstanding at a time. `mem_valid` is never high while `busy` is low.
- R9: A `vblank` pulse that arrives while `busy` is high has no effect on the walk in progress.
- R10: If software writes the start register in the same cycle the walk completes, the software value is kept and the hardware clear is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank | input | 1 | One-cycle vertical blank strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall on the same clock edge: software writing the start register, and the hardware clearing it when the final reply write is accepted. The bench sees the handshake of that final write coming one half-cycle ahead. In that same cycle it drives a start write, then reads the register back and expects the software value. It also pulses `vblank` in the middle of a walk and after completion, and expects no second walk in either case. A behavioural model predicts `busy`, `done`, read data and every memory access, and it is compared with the design on each clock while `mem_ready` follows an irregular pattern.

// File: rtl/walker_pkg.sv
package walker_pkg;

  localparam int unsigned REG_IDX_W = 2;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LEN_W     = 8;
  localparam int unsigned LAST_BIT  = 31;
  localparam int unsigned HDR_BYTES = 8;

  localparam logic [REG_IDX_W-1:0] RI_BASE = 2'd0;
  localparam logic [REG_IDX_W-1:0] RI_EN   = 2'd1;
  localparam logic [REG_IDX_W-1:0] RI_GO   = 2'd2;
  localparam logic [REG_IDX_W-1:0] RI_SYS  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CMD,
    ST_RD_DST,
    ST_WR_LO,
    ST_WR_HI
  } walk_st_t;

endpackage

// File: rtl/walker_regs.sv
module walker_regs
  import walker_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [15:0] MAGIC  = 16'h3A98
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [REG_IDX_W-1:0] addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  input  logic                 hw_clr,
  output logic [ADDR_W-1:0]    table_base,
  output logic                 armed
);

  logic [WORD_W-1:0] base_q, en_q, go_q, sys_q;
  logic              sw_go;

  assign sw_go = we && (addr == RI_GO);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      en_q   <= '0;
      go_q   <= '0;
      sys_q  <= '0;
      rdata  <= '0;
    end else begin
      if (we && addr == RI_BASE) base_q <= wdata;
      if (we && addr == RI_EN)   en_q   <= wdata;
      if (we && addr == RI_SYS)  sys_q  <= wdata;
      if (sw_go)       go_q <= wdata;
      else if (hw_clr) go_q <= '0;
      case (addr)
        RI_BASE: rdata <= base_q;
        RI_EN:   rdata <= en_q;
        RI_GO:   rdata <= go_q;
        default: rdata <= sys_q;
      endcase
    end
  end

  assign table_base = base_q[ADDR_W-1:0];
  assign armed = (sys_q[WORD_W-1 -: 16] == MAGIC) &&
                 (en_q == WORD_W'(1)) && (go_q == WORD_W'(1));

  // R7: completion clears the start word
  a_r7_go_cleared: assert property (@(posedge clk) disable iff (rst)
    hw_clr && !sw_go |=> go_q == '0);

  // R10: a simultaneous software write wins
  a_r10_sw_wins: assert property (@(posedge clk) disable iff (rst)
    hw_clr && sw_go |=> go_q == $past(wdata));

endmodule

// File: rtl/walker_next_addr.sv
module walker_next_addr
  import walker_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] entry,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] next_entry
);

  logic [ADDR_W-1:0] body_bytes;

  assign body_bytes = (ADDR_W'(len) + ADDR_W'(1)) << 2;
  assign next_entry = entry + ADDR_W'(HDR_BYTES) + body_bytes;

endmodule

// File: rtl/walker_fsm.sv
module walker_fsm
  import walker_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vblank,
  input  logic              armed,
  input  logic [ADDR_W-1:0] table_base,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              hw_clr
);

  walk_st_t          st;
  logic [ADDR_W-1:0] entry_q, dst_q, next_entry;
  logic [LEN_W-1:0]  len_q;
  logic              last_q;

  walker_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .entry      (entry_q),
    .len        (len_q),
    .next_entry (next_entry)
  );

  assign hw_clr = (st == ST_WR_HI) && mem_ready && last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mem_valid <= 1'b0;
      mem_write <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      entry_q   <= '0;
      dst_q     <= '0;
      len_q     <= '0;
      last_q    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (vblank && armed) begin
          st        <= ST_RD_CMD;
          entry_q   <= table_base;
          mem_addr  <= table_base;
          mem_valid <= 1'b1;
          mem_write <= 1'b0;
          busy      <= 1'b1;
        end
        ST_RD_CMD: if (mem_ready) begin
          last_q   <= mem_rdata[LAST_BIT];
          len_q    <= mem_rdata[LEN_W-1:0];
          mem_addr <= entry_q + ADDR_W'(4);
          st       <= ST_RD_DST;
        end
        ST_RD_DST: if (mem_ready) begin
          dst_q     <= mem_rdata[ADDR_W-1:0];
          mem_addr  <= mem_rdata[ADDR_W-1:0];
          mem_write <= 1'b1;
          mem_wdata <= '0;
          st        <= ST_WR_LO;
        end
        ST_WR_LO: if (mem_ready) begin
          mem_addr  <= dst_q + ADDR_W'(4);
          mem_wdata <= '1;
          st        <= ST_WR_HI;
        end
        ST_WR_HI: if (mem_ready) begin
          mem_write <= 1'b0;
          if (last_q) begin
            st        <= ST_IDLE;
            mem_valid <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b1;
          end else begin
            entry_q  <= next_entry;
            mem_addr <= next_entry;
            st       <= ST_RD_CMD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8: request held steady until accepted
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_write) && $stable(mem_wdata));

  // R8: no access outside a walk
  a_r8_valid_in_walk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> busy);

  // R3: a walk only starts from a qualified strobe
  a_r3_start_qualified: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(vblank && armed));

  // R5: only the two reply patterns are written
  a_r5_reply_pattern: assert property (@(posedge clk) disable iff (rst)
    mem_valid && mem_write |-> (mem_wdata == '0 || mem_wdata == '1));

  // R7: busy falls together with the completion pulse
  a_r7_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/vbl_dma_walker.sv
module vbl_dma_walker
  import walker_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [15:0] MAGIC  = 16'h3A98
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vblank,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done
);

  logic [ADDR_W-1:0] table_base;
  logic              armed, hw_clr;

  walker_regs #(.ADDR_W(ADDR_W), .MAGIC(MAGIC)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .hw_clr     (hw_clr),
    .table_base (table_base),
    .armed      (armed)
  );

  walker_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .vblank     (vblank),
    .armed      (armed),
    .table_base (table_base),
    .mem_valid  (mem_valid),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .done       (done),
    .hw_clr     (hw_clr)
  );

  // R9: a strobe during a walk does not restart it
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy && vblank && !done |=> busy || done);

endmodule

// File: tb/test_vbl_dma_walker.sv
`timescale 1ns/1ps
module test_vbl_dma_walker;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vblank = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata;
  logic        busy, done;

  always #4 clk = ~clk;

  vbl_dma_walker i_vbl_dma_walker (
    .clk(clk), .rst(rst), .vblank(vblank),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .busy(busy), .done(done)
  );

  logic [31:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[9:2]];

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  // model state
  logic [31:0] mreg [0:3];
  bit          m_busy = 0;
  bit          m_done = 0;
  logic [31:0] m_rdata = '0;
  logic [31:0] qa[$];
  logic [31:0] qd[$];
  bit          qw[$];
  bit          ql[$];
  string       qt[$];

  // pending stimulus
  bit          p_we = 0;
  logic [1:0]  p_addr = 2'd0;
  logic [31:0] p_wdata = '0;
  bit          p_vbl = 0;
  bit          inj_r10 = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic build_walk();
    logic [31:0] a, cmd, dst;
    string tg;
    a = mreg[0];
    tg = "R4";
    for (int n = 0; n < 16; n++) begin
      cmd = mem[a[9:2]];
      dst = mem[(a + 32'd4) >> 2];
      qa.push_back(a);           qw.push_back(0); qd.push_back('0); ql.push_back(0); qt.push_back(tg);
      qa.push_back(a + 32'd4);   qw.push_back(0); qd.push_back('0); ql.push_back(0); qt.push_back(tg);
      qa.push_back(dst);         qw.push_back(1); qd.push_back(32'h0); ql.push_back(0); qt.push_back("R5");
      qa.push_back(dst + 32'd4); qw.push_back(1); qd.push_back(32'hFFFFFFFF);
      ql.push_back(cmd[31]); qt.push_back("R5");
      if (cmd[31]) break;
      a = a + 32'd8 + (({24'd0, cmd[7:0]} + 32'd1) * 32'd4);
      tg = "R6";
    end
  endtask

  task automatic step();
    bit last_acc, was_busy, qual;
    logic [31:0] rd_next;
    @(negedge clk);
    chk(busy === m_busy, "R3 R7 R9", "busy", {31'd0, busy}, {31'd0, m_busy});
    chk(done === m_done, "R7", "done", {31'd0, done}, {31'd0, m_done});
    chk(mem_valid === m_busy, "R8", "mem_valid", {31'd0, mem_valid}, {31'd0, m_busy});
    chk(reg_rdata === m_rdata, "R2", "reg_rdata", reg_rdata, m_rdata);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = lfsr[0] | lfsr[3];
    vblank = p_vbl;
    p_vbl = 0;
    if (inj_r10 && m_busy && mem_ready && qa.size() == 1) begin
      reg_we = 1; reg_addr = 2'd2; reg_wdata = 32'd1; inj_r10 = 0;
    end else begin
      reg_we = p_we; reg_addr = p_addr; reg_wdata = p_wdata;
    end
    p_we = 0;
    rd_next = mreg[reg_addr];
    was_busy = m_busy;
    last_acc = 0;
    if (m_busy && mem_ready && qa.size() > 0) begin
      chk(mem_addr === qa[0], qt[0], "mem_addr", mem_addr, qa[0]);
      chk(mem_write === qw[0], qt[0], "mem_write", {31'd0, mem_write}, {31'd0, qw[0]});
      if (qw[0]) begin
        chk(mem_wdata === qd[0], qt[0], "mem_wdata", mem_wdata, qd[0]);
        mem[mem_addr[9:2]] = mem_wdata;
      end
      last_acc = ql[0];
      void'(qa.pop_front()); void'(qw.pop_front()); void'(qd.pop_front());
      void'(ql.pop_front()); void'(qt.pop_front());
    end
    qual = (mreg[3][31:16] == 16'h3A98) && (mreg[1] == 32'd1) && (mreg[2] == 32'd1);
    if (last_acc) begin
      m_busy = 0;
      mreg[2] = '0;
    end
    if (!was_busy && vblank && qual) begin
      m_busy = 1;
      build_walk();
    end
    if (reg_we) mreg[reg_addr] = reg_wdata;
    m_done = last_acc;
    m_rdata = rd_next;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    p_we = 1; p_addr = a; p_wdata = d;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic run_walk();
    for (int i = 0; i < 400 && m_busy; i++) step();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 4; i++) mreg[i] = '0;
    // table at 0x40: entry0 len 1, entry1 len 0, entry2 final len 3
    mem[32'h40 >> 2] = 32'h0003_0701;
    mem[32'h44 >> 2] = 32'h0000_0200;
    mem[32'h50 >> 2] = 32'h0001_0000;
    mem[32'h54 >> 2] = 32'h0000_0208;
    mem[32'h5C >> 2] = 32'h8002_0303;
    mem[32'h60 >> 2] = 32'h0000_0210;
    mem[32'h200 >> 2] = 32'h1234_5678;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(busy === 1'b0, "R1", "busy", {31'd0, busy}, 32'd0);
    chk(done === 1'b0, "R1", "done", {31'd0, done}, 32'd0);
    chk(mem_valid === 1'b0, "R1", "mem_valid", {31'd0, mem_valid}, 32'd0);
    chk(reg_rdata === 32'd0, "R1", "reg_rdata", reg_rdata, 32'd0);
    wr(2'd0, 32'h40);
    wr(2'd1, 32'd1);
    wr(2'd2, 32'd1);
    wr(2'd3, 32'h3A97_0000);
    idle(3);
    // R3: wrong magic, then wrong enable word
    p_vbl = 1; step(); idle(5);
    wr(2'd3, 32'h3A98_1234);
    wr(2'd1, 32'd2);
    p_vbl = 1; step(); idle(5);
    wr(2'd1, 32'd1);
    p_addr = 2'd3; idle(2);
    chk(reg_rdata === 32'h3A98_1234, "R2", "sysctrl readback", reg_rdata, 32'h3A98_1234);
    // main walk with a strobe in the middle (R9)
    p_vbl = 1; step();
    idle(6);
    p_vbl = 1; step();
    run_walk();
    idle(1);
    p_addr = 2'd2; idle(2);
    chk(reg_rdata === 32'd0, "R7", "start cleared", reg_rdata, 32'd0);
    chk(mem[32'h200 >> 2] === 32'd0, "R5", "reply word 0", mem[32'h200 >> 2], 32'd0);
    // start word zero: no new walk
    p_vbl = 1; step(); idle(5);
    // R10: software write on the completion edge
    wr(2'd2, 32'd1);
    inj_r10 = 1;
    p_vbl = 1; step();
    run_walk();
    p_addr = 2'd2; idle(2);
    chk(reg_rdata === 32'd1, "R10", "start kept", reg_rdata, 32'd1);
    wr(2'd1, 32'd0);
    idle(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule